// File: doc/BRIEF.md
# Vector Narrowing Right-Shift Unit

This block takes a 128-bit vector of wide integer lanes and shifts every lane right by one immediate amount. It then narrows each lane to half its width and packs the narrow lanes into a 64-bit result. A 3-bit operation code chooses how a lane is narrowed. The low two bits pick plain truncation, signed saturation, unsigned saturation, or signed-input-to-unsigned-output saturation. The top bit adds a rounding constant before the shift. A 2-bit size code picks the lane width.

Rounding is computed on each lane after it is widened to twice its width. The carry out of the rounding addition is therefore never lost. Signed-input variants sign-extend the lane before widening. The other variants zero-extend it.

Operands are accepted with a valid/ready handshake into a single output register. That register is controlled by a two-state machine:

- OR_EMPTY: the register holds nothing.
- OR_FULL: the register holds a result that has not been consumed yet.

The machine has these transitions:

- accept: OR_EMPTY goes to OR_FULL when an operand is taken.
- drain: OR_FULL goes to OR_EMPTY when the result leaves and no new operand arrives.
- refill: OR_FULL stays in OR_FULL when a result leaves and a new operand arrives in the same cycle.
- stall: OR_FULL stays in OR_FULL while the consumer is not ready.

Top module: `vns_narrow_shift`

## Requirements
- R1: The size code selects the lane layout. 0 means eight 16-bit lanes narrowed to 8 bits, 1 means four 32-bit lanes narrowed to 16 bits, and 2 means two 64-bit lanes narrowed to 32 bits. Input lane i occupies bits [i*W +: W] and its result occupies output bits [i*W/2 +: W/2].
- R2: Operation code 000 shifts the zero-extended lane logically right and keeps the low W/2 bits, with no clamping.
- R3: Operation code 001 shifts the sign-extended lane arithmetically right and clamps the result to the signed narrow range, from -2^(W/2-1) to 2^(W/2-1)-1.
- R4: Operation code 010 shifts the zero-extended lane logically right and clamps the result to at most 2^(W/2)-1.
- R5: Operation code 011 shifts the sign-extended lane arithmetically right and clamps the result to the range 0 to 2^(W/2)-1.
- R6: When operation bit 2 is set, 1 << (shift-1) is added to the lane before the shift. The addition is done at double width using the extension of the chosen variant, so a carry out of the lane's top bit is kept. For example, 16-bit lane 0xFFFF with code 110 and shift 1 gives 0xFF.
- R7: Code 100 with a shift equal to W/2 returns the upper half of (lane + 2^(W/2-1)), taken at double width.
- R8: A shift of 0, a shift greater than W/2, or size code 3 registers out_err=1 with out_vec equal to zero. Otherwise out_err is 0.
- R9: in_ready is high when the output register is empty or out_ready is high. An operand is taken when in_valid and in_ready are both high. Its result appears on out_vec with out_valid high from the next cycle.
- R10: While out_valid is high and out_ready is low, out_valid, out_vec and out_err hold their values.
- R11: During and directly after reset, out_valid, out_err and out_vec are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_vec | input | 128 | Wide-lane source vector |
| in_op | input | 3 | Bit 2 selects rounding; bits 1:0 select the narrowing kind |
| in_size | input | 2 | Lane layout code |
| in_shift | input | 6 | Right-shift immediate |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vec | output | 64 | Packed narrow result |
| out_err | output | 1 | Illegal shift or size code |

## Verification
A wrong state bit in the output machine shows up at the ports within one cycle. It appears as in_ready disagreeing with out_ready, as a lost result, or as a result presented twice. The bench therefore compares in_ready and out_valid on every clock. A lane arithmetic fault appears only in the affected lanes and only for the variant that uses the faulty path. For that reason the stimulus covers every operation code and every size, with shifts at 1, at the narrow width, and just beyond it, plus carry-producing and sign-boundary lane values.

// File: rtl/vns_pkg.sv
package vns_pkg;

    typedef enum logic [1:0] {
        NAR_TRUNC = 2'b00,
        NAR_SSAT  = 2'b01,
        NAR_USAT  = 2'b10,
        NAR_S2U   = 2'b11
    } nar_kind_e;

    typedef enum logic [1:0] {
        LANE_16  = 2'b00,
        LANE_32  = 2'b01,
        LANE_64  = 2'b10,
        LANE_RSV = 2'b11
    } lane_cfg_e;

    typedef enum logic {
        OR_EMPTY = 1'b0,
        OR_FULL  = 1'b1
    } oreg_state_e;

endpackage

// File: rtl/vns_lane.sv
module vns_lane
    import vns_pkg::*;
#(
    parameter int W       = 16,
    parameter int SHIFT_W = 6
) (
    input  logic [W-1:0]       lane_in,
    input  logic [2:0]         op,
    input  logic [SHIFT_W-1:0] sh,
    output logic [W/2-1:0]     lane_out
);
    localparam int N = W / 2;
    localparam int X = 2 * W;
    localparam logic [X-1:0] ONE  = {{(X-1){1'b0}}, 1'b1};
    localparam logic [X-1:0] SMAX = {{(X-N+1){1'b0}}, {(N-1){1'b1}}};
    localparam logic [X-1:0] SMIN = {{(X-N+1){1'b1}}, {(N-1){1'b0}}};
    localparam logic [X-1:0] UMAX = {{(X-N){1'b0}}, {N{1'b1}}};

    nar_kind_e  kind;
    logic       rnd;
    logic       sgn;
    logic [X-1:0] ext;
    logic [X-1:0] rc;
    logic [X-1:0] sum;
    logic [X-1:0] shr;

    always_comb begin
        kind = nar_kind_e'(op[1:0]);
        rnd  = op[2];
        sgn  = (kind == NAR_SSAT) || (kind == NAR_S2U);
        ext  = sgn ? {{W{lane_in[W-1]}}, lane_in} : {{W{1'b0}}, lane_in};
        rc   = rnd ? (ONE << (sh - 1'b1)) : '0;
        sum  = ext + rc;
        if (sgn) shr = $signed(sum) >>> sh;
        else     shr = sum >> sh;
    end

    always_comb begin
        unique case (kind)
            NAR_TRUNC: lane_out = shr[N-1:0];
            NAR_SSAT: begin
                if ($signed(shr) > $signed(SMAX))      lane_out = SMAX[N-1:0];
                else if ($signed(shr) < $signed(SMIN)) lane_out = SMIN[N-1:0];
                else                                   lane_out = shr[N-1:0];
            end
            NAR_USAT: begin
                if (shr > UMAX) lane_out = UMAX[N-1:0];
                else            lane_out = shr[N-1:0];
            end
            NAR_S2U: begin
                if (shr[X-1])        lane_out = '0;
                else if (shr > UMAX) lane_out = UMAX[N-1:0];
                else                 lane_out = shr[N-1:0];
            end
        endcase
    end
endmodule

// File: rtl/vns_datapath.sv
module vns_datapath
    import vns_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int MIN_W   = 16,
    parameter int NUM_CFG = 3,
    parameter int SHIFT_W = 6
) (
    input  logic [VEC_W-1:0]   vec,
    input  logic [2:0]         op,
    input  logic [1:0]         size,
    input  logic [SHIFT_W-1:0] sh,
    output logic [VEC_W/2-1:0] res,
    output logic               err
);
    localparam int RES_W = VEC_W / 2;

    logic [RES_W-1:0] cfg_res [NUM_CFG];

    for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
        localparam int W = MIN_W << c;
        localparam int L = VEC_W / W;
        localparam int N = W / 2;
        logic [RES_W-1:0] packed_res;
        for (genvar l = 0; l < L; l++) begin : g_lane
            vns_lane #(.W(W), .SHIFT_W(SHIFT_W)) u_lane (
                .lane_in (vec[l*W +: W]),
                .op      (op),
                .sh      (sh),
                .lane_out(packed_res[l*N +: N])
            );
        end
        assign cfg_res[c] = packed_res;
    end

    logic [SHIFT_W:0]  limit;
    logic              sh_ok;
    logic [RES_W-1:0]  picked;

    always_comb begin
        limit  = '0;
        picked = '0;
        unique case (lane_cfg_e'(size))
            LANE_16: begin limit = (SHIFT_W+1)'(MIN_W / 2);      picked = cfg_res[0]; end
            LANE_32: begin limit = (SHIFT_W+1)'(MIN_W);          picked = cfg_res[1]; end
            LANE_64: begin limit = (SHIFT_W+1)'(MIN_W * 2);      picked = cfg_res[2]; end
            LANE_RSV: begin limit = '0;                          picked = '0;         end
        endcase
        sh_ok = (sh != '0) && ({1'b0, sh} <= limit);
        err   = !sh_ok;
        res   = err ? '0 : picked;
    end
endmodule

// File: rtl/vns_outreg.sv
module vns_outreg
    import vns_pkg::*;
#(
    parameter int D_W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [D_W-1:0] d_data,
    input  logic           d_err,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [D_W-1:0] out_data,
    output logic           out_err
);
    oreg_state_e state, state_nx;
    logic        take;

    always_comb begin
        in_ready = (state == OR_EMPTY) || out_ready;
        take     = in_valid && in_ready;
        unique case (state)
            OR_EMPTY: state_nx = take ? OR_FULL : OR_EMPTY;
            OR_FULL:  state_nx = take ? OR_FULL : (out_ready ? OR_EMPTY : OR_FULL);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= OR_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_err  <= 1'b0;
        end else if (take) begin
            out_data <= d_data;
            out_err  <= d_err;
        end
    end

    assign out_valid = (state == OR_FULL);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err));

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/vns_narrow_shift.sv
module vns_narrow_shift
    import vns_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int MIN_W   = 16,
    parameter int NUM_CFG = 3,
    parameter int SHIFT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [VEC_W-1:0]   in_vec,
    input  logic [2:0]         in_op,
    input  logic [1:0]         in_size,
    input  logic [SHIFT_W-1:0] in_shift,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [VEC_W/2-1:0] out_vec,
    output logic               out_err
);
    localparam int RES_W = VEC_W / 2;

    logic [RES_W-1:0] dp_res;
    logic             dp_err;

    vns_datapath #(
        .VEC_W(VEC_W), .MIN_W(MIN_W), .NUM_CFG(NUM_CFG), .SHIFT_W(SHIFT_W)
    ) u_dp (
        .vec (in_vec),
        .op  (in_op),
        .size(in_size),
        .sh  (in_shift),
        .res (dp_res),
        .err (dp_err)
    );

    vns_outreg #(.D_W(RES_W)) u_oreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .d_data   (dp_res),
        .d_err    (dp_err),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_vec),
        .out_err  (out_err)
    );

    assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> out_vec == '0);

    assert_idle_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && !out_err && out_vec == '0);
endmodule

// File: tb/vns_narrow_shift_tb.sv
module vns_narrow_shift_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_vec = '0;
    logic [2:0]   in_op = '0;
    logic [1:0]   in_size = '0;
    logic [5:0]   in_shift = 6'd1;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [63:0]  out_vec;
    logic         out_err;

    int checks = 0;
    int fails  = 0;

    // model state
    bit          m_full = 0;
    logic [63:0] m_data = '0;
    logic        m_err  = 0;
    string       m_tag  = "R11";

    always #5 clk = ~clk;

    vns_narrow_shift dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_vec(in_vec), .in_op(in_op), .in_size(in_size), .in_shift(in_shift),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_vec(out_vec), .out_err(out_err)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference: per-lane arithmetic on wide signed integers
    function automatic logic [63:0] ref_vec(input logic [127:0] v, input logic [2:0] op,
                                            input logic [1:0] sz, input logic [5:0] sh,
                                            output logic e);
        logic [63:0] r = '0;
        int w, n;
        e = 1'b0;
        if (sz == 2'd3) begin e = 1'b1; return '0; end
        w = 16 << sz;
        n = w / 2;
        if (sh == 0 || int'(sh) > n) begin e = 1'b1; return '0; end
        for (int lane = 0; lane < 128 / w; lane++) begin
            logic signed [135:0] x, lo, hi;
            x = '0;
            for (int b = 0; b < w; b++) x[b] = v[lane*w + b];
            if ((op[1:0] == 2'b01 || op[1:0] == 2'b11) && x[w-1])
                x = x - (136'sd1 <<< w);
            if (op[2]) x = x + (136'sd1 <<< (sh - 1));
            x = x >>> sh;
            if (op[1:0] == 2'b01) begin
                lo = -(136'sd1 <<< (n - 1));
                hi = (136'sd1 <<< (n - 1)) - 136'sd1;
            end else begin
                lo = 136'sd0;
                hi = (136'sd1 <<< n) - 136'sd1;
            end
            if (op[1:0] != 2'b00) begin
                if (x > hi) x = hi;
                if (x < lo) x = lo;
            end
            for (int b = 0; b < n; b++) r[lane*n + b] = x[b];
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic [1:0] sz,
                                     input logic [5:0] sh, input logic e);
        if (e) return "R8";
        if (op == 3'b100 && int'(sh) == (8 << sz)) return "R7";
        if (op[2]) return "R1/R6";
        case (op[1:0])
            2'b00: return "R1/R2";
            2'b01: return "R1/R3";
            2'b10: return "R1/R4";
            default: return "R1/R5";
        endcase
    endfunction

    // one clock of stimulus, port comparison against the model, model update
    task automatic cycle(input logic iv, input logic [127:0] v, input logic [2:0] op,
                         input logic [1:0] sz, input logic [5:0] sh, input logic ordy);
        bit          fire;
        logic        e;
        logic [63:0] d;
        @(negedge clk);
        in_valid = iv; in_vec = v; in_op = op; in_size = sz; in_shift = sh; out_ready = ordy;
        #1;
        chk("R9 in_ready", {63'd0, in_ready}, {63'd0, (!m_full) || ordy});
        chk("R9/R10 out_valid", {63'd0, out_valid}, {63'd0, m_full});
        if (m_full) begin
            chk(m_tag, out_vec, m_data);
            chk({m_tag, " err"}, {63'd0, out_err}, {63'd0, m_err});
        end
        fire = iv && (!m_full || ordy);
        d = ref_vec(v, op, sz, sh, e);
        @(posedge clk);
        if (fire) begin
            m_full = 1; m_data = d; m_err = e; m_tag = tag_of(op, sz, sh, e);
        end else if (ordy) begin
            m_full = 0;
        end else if (m_full) begin
            m_tag = "R10";
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [127:0] pat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R11 out_err", {63'd0, out_err}, 64'd0);
        chk("R11 out_vec", out_vec, 64'd0);
        rst_n = 1'b1;

        pat = 128'h7FFF_8000_FFFF_0001_1234_80FF_7F80_00FF;
        for (int op = 0; op < 8; op++)
            for (int sz = 0; sz < 3; sz++) begin
                cycle(1, pat, 3'(op), 2'(sz), 6'd1, 1);
                cycle(1, pat, 3'(op), 2'(sz), 6'(8 << sz), 1);
                cycle(1, ~pat, 3'(op), 2'(sz), 6'(3 + sz), 1);
            end
        // R6: carry kept, 0xFFFF rounding unsigned sat shift 1 -> 0xFF
        cycle(1, {8{16'hFFFF}}, 3'b110, 2'd0, 6'd1, 1);
        cycle(1, {8{16'hFFFF}}, 3'b100, 2'd0, 6'd1, 1);
        // R7 at every size
        cycle(1, {8{16'h7F80}}, 3'b100, 2'd0, 6'd8, 1);
        cycle(1, {4{32'hFFFF_8000}}, 3'b100, 2'd1, 6'd16, 1);
        cycle(1, {2{64'h8000_0000_8000_0000}}, 3'b100, 2'd2, 6'd32, 1);
        // R8: illegal shift / size
        cycle(1, pat, 3'b001, 2'd0, 6'd0, 1);
        cycle(1, pat, 3'b001, 2'd0, 6'd9, 1);
        cycle(1, pat, 3'b000, 2'd1, 6'd17, 1);
        cycle(1, pat, 3'b000, 2'd2, 6'd33, 1);
        cycle(1, pat, 3'b010, 2'd3, 6'd4, 1);
        cycle(0, pat, 3'b010, 2'd0, 6'd4, 1);
        // R10: stall with pending operand
        cycle(1, pat, 3'b011, 2'd1, 6'd2, 0);
        cycle(1, ~pat, 3'b001, 2'd1, 6'd2, 0);
        cycle(1, ~pat, 3'b001, 2'd1, 6'd2, 0);
        cycle(0, pat, 3'b000, 2'd0, 6'd1, 1);
        cycle(0, pat, 3'b000, 2'd0, 6'd1, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]   sz;
            logic [5:0]   sh;
            logic [127:0] v;
            int           k;
            sz = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            sh = 6'($urandom_range(0, (8 << (sz == 2'd3 ? 0 : sz)) + 1));
            k  = $urandom_range(0, 5);
            v  = {$urandom(), $urandom(), $urandom(), $urandom()};
            if (k == 0) v = '1;
            if (k == 1) v = {8{16'h8000}} ^ {2{64'h0000_8000_0000_0000}};
            if (k == 2) v = {2{64'h7FFF_FFFF_FFFF_FFFF}};
            cycle($urandom_range(0, 3) != 0, v, 3'($urandom_range(0, 7)), sz, sh,
                  $urandom_range(0, 2) != 0);
        end
        cycle(0, '0, 3'd0, 2'd0, 6'd1, 1);
        cycle(0, '0, 3'd0, 2'd0, 6'd1, 1);
        summary();
        $finish;
    end
endmodule